// File: doc/BRIEF.md
# DMA Falling-Edge Request Acceptor

This block qualifies an external active-low DMA request line for one channel that is set up to start on falling edges. The line passes through a synchronizer. It is then sampled on every rising clock edge. While the block is open to requests, a sampled low level is latched as a pending request. The pending request is held until the controller's arbiter starts the transfer. At that point it is cleared and acceptance closes.

After activation, the block waits for two things: a sampled high level on the line, which completes the edge, and the end of the transfer's write cycle. Only when both have happened does it open to requests again. The sequence repeats for each transfer. A transfer-end pulse, a write that disables the channel, or reset sends the block back to idle.

A controller uses the pending-request output as the channel's request into arbitration. The accepting flag shows when a new falling edge can be taken.

Top module: `dreq_edge_acceptor`

## Requirements
- R1: During reset and right after it, both `req_pend` and `accepting` are 0.
- R2: A cycle with `en_wr`=1 and `en_val`=1 opens acceptance. `accepting` is 1 in the next cycle and `req_pend` is 0.
- R3: With `SYNC_STAGES`=2, a low level on `req_n` appears as `req_pend`=1 three rising edges after the line changes.
- R4: A low synchronized sample taken while accepting latches `req_pend`=1 and drops `accepting`. The request stays pending while the line goes high again, until activation.
- R5: An `act_stb` pulse while a request is pending makes `req_pend` 0 and keeps `accepting` 0 in the next cycle.
- R6: After activation, if a high synchronized sample has been seen by the cycle of `wr_done`, `accepting` is 1 in the cycle after `wr_done`.
- R7: If the synchronized line has not been high by the end of the write cycle, acceptance stays closed. It opens in the cycle after the first high sample.
- R8: If `act_stb` arrives in the same cycle as a low sample taken while accepting, activation wins. No request is latched and acceptance closes.
- R9: A `xfer_end` pulse, or an enable write with `en_val`=0, makes both outputs 0 in the next cycle.
- R10: `req_pend` and `accepting` are never 1 together. A low line has no effect while the channel is not enabled.
- R11: After acceptance reopens, a new falling edge is taken and held again in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_n | input | 1 | Asynchronous active-low request line |
| en_wr | input | 1 | Pulse: the write to the channel's enable bit completes this cycle |
| en_val | input | 1 | Value written with `en_wr` (1 enables, 0 disables) |
| act_stb | input | 1 | Pulse: the arbiter activates the channel |
| wr_done | input | 1 | Pulse: the DMA write cycle ends this cycle |
| xfer_end | input | 1 | Pulse: the whole transfer has ended |
| req_pend | output | 1 | A request is latched and waits for activation |
| accepting | output | 1 | The block will latch a low sample |

## Verification
The bench sweeps two timings against each other. One is the cycle in which the line returns high, from before activation to well after it. The other is the cycle of the write-done pulse. For each pair, the expected reopening cycle is computed as the latest of the three events that reopening waits for.

A design that re-armed on the high level alone would reopen too early. A design that re-armed on write-done alone would take the same low level twice. A design that cleared the request when the line went high would drop the request before activation. A separate case puts activation in the same cycle as a fresh low sample, where a wrong priority leaves a stray pending request. Further cases check that a low line is ignored while the channel is idle, and that disable and transfer-end return the block to idle.

// File: rtl/dreq_acc_pkg.sv
// Package: shared types for the falling-edge request acceptor.
// Assumes one channel per acceptor instance.
package dreq_acc_pkg;

    // Acceptor phases: off, open to requests, request held, waiting to re-arm
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_HELD   = 2'd2,
        ST_REARM  = 2'd3
    } acc_state_e;

endpackage

// File: rtl/dreq_sync.sv
// Module: multi-flop synchronizer for the asynchronous request line.
// Assumes the line is idle-high, so the chain resets to 1.
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    // Stage 0 captures the raw line
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b1;
        else        chain_q[0] <= async_in;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Each later stage re-registers the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gi] <= 1'b1;
                else        chain_q[gi] <= chain_q[gi-1];
            end
        end
    endgenerate

    assign sync_out = chain_q[LAST];
endmodule

// File: rtl/dreq_arm_fsm.sv
// Module: accept / hold / clear / re-arm sequencer for one channel.
// Assumes line_lvl is already synchronized and sampled once per clock.
// Idle requests (disable, transfer end) take priority over enable,
// and enable takes priority over the normal sequence.
module dreq_arm_fsm
    import dreq_acc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_lvl,
    input  logic en_wr,
    input  logic en_val,
    input  logic act_stb,
    input  logic wr_done,
    input  logic xfer_end,
    output logic req_pend,
    output logic accepting
);
    acc_state_e state_q, state_d;
    logic       hi_seen_q, hi_seen_d;
    logic       wr_seen_q, wr_seen_d;
    logic       hi_now, wr_now;

    // Merge the remembered and present events of the re-arm condition
    always_comb begin
        hi_now = hi_seen_q | line_lvl;
        wr_now = wr_seen_q | wr_done;
    end

    // Next-state and re-arm flag logic
    always_comb begin
        state_d   = state_q;
        hi_seen_d = hi_seen_q;
        wr_seen_d = wr_seen_q;
        if (xfer_end || (en_wr && !en_val)) begin
            state_d   = ST_IDLE;
            hi_seen_d = 1'b0;
            wr_seen_d = 1'b0;
        end else if (en_wr && en_val) begin
            state_d   = ST_OPEN;
            hi_seen_d = 1'b0;
            wr_seen_d = 1'b0;
        end else begin
            case (state_q)
                ST_OPEN: begin
                    if (act_stb) begin
                        state_d   = ST_REARM;
                        hi_seen_d = 1'b0;
                        wr_seen_d = 1'b0;
                    end else if (!line_lvl) begin
                        state_d = ST_HELD;
                    end
                end
                ST_HELD: begin
                    if (act_stb) begin
                        state_d   = ST_REARM;
                        hi_seen_d = 1'b0;
                        wr_seen_d = 1'b0;
                    end
                end
                ST_REARM: begin
                    if (hi_now && wr_now) begin
                        state_d   = ST_OPEN;
                        hi_seen_d = 1'b0;
                        wr_seen_d = 1'b0;
                    end else begin
                        hi_seen_d = hi_now;
                        wr_seen_d = wr_now;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            hi_seen_q <= 1'b0;
            wr_seen_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            hi_seen_q <= hi_seen_d;
            wr_seen_q <= wr_seen_d;
        end
    end

    assign req_pend  = (state_q == ST_HELD);
    assign accepting = (state_q == ST_OPEN);
endmodule

// File: rtl/dreq_edge_acceptor.sv
// Module: top of the falling-edge request acceptor.
// Synchronizes the request line and feeds it to the re-arm sequencer.
// Assumes all strobes are single-cycle and synchronous to clk.
module dreq_edge_acceptor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic en_wr,
    input  logic en_val,
    input  logic act_stb,
    input  logic wr_done,
    input  logic xfer_end,
    output logic req_pend,
    output logic accepting
);
    logic line_sync;

    dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_n),
        .sync_out (line_sync)
    );

    dreq_arm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_lvl  (line_sync),
        .en_wr     (en_wr),
        .en_val    (en_val),
        .act_stb   (act_stb),
        .wr_done   (wr_done),
        .xfer_end  (xfer_end),
        .req_pend  (req_pend),
        .accepting (accepting)
    );
endmodule

// File: rtl/dreq_acc_chk.sv
// Module: port-level property checker for dreq_edge_acceptor.
// Assumes it is bound to the top and sees only its ports.
module dreq_acc_chk (
    input logic clk,
    input logic rst_n,
    input logic en_wr,
    input logic en_val,
    input logic act_stb,
    input logic xfer_end,
    input logic req_pend,
    input logic accepting
);
    // R10
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_pend && accepting));

    // R2
    enable_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr && en_val && !xfer_end) |=> (accepting && !req_pend));

    // R4
    hold_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pend && !act_stb && !xfer_end && !en_wr) |=> req_pend);

    // R5
    act_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_pend && act_stb && !xfer_end && !en_wr) |=> (!req_pend && !accepting));

    // R8
    act_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accepting && act_stb && !xfer_end && !en_wr) |=> (!req_pend && !accepting));

    // R9
    to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_end || (en_wr && !en_val)) |=> (!req_pend && !accepting));
endmodule

bind dreq_edge_acceptor dreq_acc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_wr     (en_wr),
    .en_val    (en_val),
    .act_stb   (act_stb),
    .xfer_end  (xfer_end),
    .req_pend  (req_pend),
    .accepting (accepting)
);

// File: tb/dreq_edge_acceptor_bench.sv
// Bench: sweeps line-release timing against write-done timing and
// computes the expected reopening cycle arithmetically.
module dreq_edge_acceptor_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1;
    logic en_wr = 1'b0;
    logic en_val = 1'b0;
    logic act_stb = 1'b0;
    logic wr_done = 1'b0;
    logic xfer_end = 1'b0;
    logic req_pend, accepting;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    dreq_edge_acceptor #(.SYNC_STAGES(2)) u_dreq_edge_acceptor (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .en_wr(en_wr), .en_val(en_val),
        .act_stb(act_stb), .wr_done(wr_done), .xfer_end(xfer_end),
        .req_pend(req_pend), .accepting(accepting)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        idle_cycles(3);
        chk("R1 req_pend in reset", req_pend, 1'b0);
        chk("R1 accepting in reset", accepting, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_pend after reset", req_pend, 1'b0);
        chk("R1 accepting after reset", accepting, 1'b0);

        // R10: low line ignored while not enabled
        req_n = 1'b0;
        idle_cycles(6);
        chk("R10 idle ignores low req_pend", req_pend, 1'b0);
        chk("R10 idle ignores low accepting", accepting, 1'b0);
        req_n = 1'b1;
        idle_cycles(4);

        // Sweep: release cycle P vs write-done cycle W, activation at A=5
        for (int p = 2; p <= 10; p++) begin
            for (int w = 6; w <= 10; w++) begin
                int e;
                e = p + 2;
                if (e < 6) e = 6;
                if (w > e) e = w;
                for (int j = 0; j <= 18; j++) begin
                    @(negedge clk);
                    if (j == 1) begin
                        chk("R2 accepting after enable", accepting, 1'b1);
                        chk("R2 no pending after enable", req_pend, 1'b0);
                    end
                    if (j == 3) chk("R3 not yet pending", req_pend, 1'b0);
                    if (j == 4) begin
                        chk("R3 R4 pending latched", req_pend, 1'b1);
                        chk("R4 acceptance closed", accepting, 1'b0);
                    end
                    if (j == 5) chk("R4 still held", req_pend, 1'b1);
                    if (j >= 6 && j <= 13) begin
                        chk("R5 cleared by activation", req_pend, 1'b0);
                        chk((e >= p + 2 && e > w) ? "R7 reopen after high" : "R6 reopen after write",
                            accepting, (j >= e + 1) ? 1'b1 : 1'b0);
                    end
                    if (j == 17) chk("R11 second edge held", req_pend, 1'b1);
                    if (j == 18) begin
                        chk("R9 xfer_end req_pend", req_pend, 1'b0);
                        chk("R9 xfer_end accepting", accepting, 1'b0);
                    end
                    en_wr    = (j == 0);
                    en_val   = (j == 0);
                    act_stb  = (j == 5);
                    wr_done  = (j == w);
                    xfer_end = (j == 17);
                    req_n    = !((j >= 1 && j < p) || j >= 14);
                end
                en_wr = 1'b0; en_val = 1'b0; act_stb = 1'b0;
                wr_done = 1'b0; xfer_end = 1'b0; req_n = 1'b1;
                idle_cycles(3);
            end
        end

        // R8: activation in the same cycle as a fresh low sample
        @(negedge clk); en_wr = 1'b1; en_val = 1'b1;
        @(negedge clk); en_wr = 1'b0; en_val = 1'b0; req_n = 1'b0;
        @(negedge clk);
        @(negedge clk); act_stb = 1'b1;
        @(negedge clk); act_stb = 1'b0;
        chk("R8 no request on tie", req_pend, 1'b0);
        chk("R8 acceptance closed on tie", accepting, 1'b0);
        wr_done = 1'b1;
        @(negedge clk); wr_done = 1'b0;
        @(negedge clk);
        chk("R7 closed while line low", accepting, 1'b0);
        req_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R7 still closed before high sample", accepting, 1'b0);
        @(negedge clk);
        chk("R7 reopened after high sample", accepting, 1'b1);

        // R9: disable write while a request is pending
        req_n = 1'b0;
        idle_cycles(3);
        chk("R4 pending before disable", req_pend, 1'b1);
        en_wr = 1'b1; en_val = 1'b0;
        @(negedge clk); en_wr = 1'b0;
        chk("R9 disable clears req_pend", req_pend, 1'b0);
        chk("R9 disable closes acceptance", accepting, 1'b0);
        idle_cycles(3);
        chk("R10 disabled ignores low", req_pend, 1'b0);

        // R1: reset in the middle of operation
        en_wr = 1'b1; en_val = 1'b1;
        @(negedge clk); en_wr = 1'b0; en_val = 1'b0;
        idle_cycles(3);
        chk("R4 pending before reset", req_pend, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears req_pend", req_pend, 1'b0);
        chk("R1 reset closes acceptance", accepting, 1'b0);
        rst_n = 1'b1; req_n = 1'b1;
        idle_cycles(2);

        finish_run();
    end
endmodule